// File: doc/BRIEF.md
# Reset Cause Recorder with Software One-Shot Resets

This block keeps a sticky record of why the system was last reset and lets software request a reset. Single-cycle pulses arrive from the power-on detector, the external reset pin, the watchdog, the low-voltage and brown-out monitors, the processor's own reset request and the processor lockup detector. Each pulse sets its own cause flag, and the flag holds until software clears it by writing a one to it. The flags are cleared only by the block's own power-domain reset. A software chip reset or core reset therefore leaves them in place, and the cause can still be read after the reset has happened.

Software can start two reset pulses, each two cycles long. One resets the whole chip and the other resets only the processor and its flash controller. It can also switch off the power-on detector with a 16-bit key. Requesting a pulse and writing the key both require the external write-protect unlock input to be high. Any later reset from the pin, the watchdog, low voltage, brown-out, a debugger reset command or a software chip reset turns the power-on detector back on. When the processor locks up, the lockup flag is always recorded. A lockup reset pulse is issued only when no debugger is attached.

Top module: `rst_cause_unit`

## Requirements
- R1: A one-cycle cause pulse sets its flag in `statusOut`, visible from the cycle after the pulse. Bit 0 is power-on or software chip reset, bit 1 the reset pin, bit 2 the watchdog, bit 3 low voltage, bit 4 brown-out, bit 5 the processor reset request, bit 7 the software core reset and bit 8 the lockup.
- R2: A write with `wrSel`=0 clears every flag whose `wrData` bit is 1 and leaves the other flags unchanged. This write does not depend on `unlocked`.
- R3: A write with `wrSel`=1, `wrData[0]`=1 and `unlocked` high drives `chipRstOut` high for exactly 2 cycles, starting the cycle after the write. It also sets status bit 0.
- R4: A write with `wrSel`=1, `wrData[1]`=1 and `unlocked` high drives `coreRstOut` high for exactly 2 cycles, starting the cycle after the write. It also sets status bit 7.
- R5: While `unlocked` is low, writes with `wrSel`=1 or `wrSel`=2 have no effect on any output.
- R6: An unlocked write with `wrSel`=2 stores `wrData[15:0]`. `porOff` is 1 from the next cycle when the stored value is 0x5AA5 and 0 for any other value.
- R7: A pin, watchdog, low-voltage, brown-out or debugger-reset pulse, or a software chip-reset request, clears the stored key so that `porOff` reads 0 in the next cycle. This takes priority over a key write in the same cycle.
- R8: A lockup pulse always sets status bit 8. `lockupRstOut` pulses for one cycle after it only when `dbgAttached` is low.
- R9: When a cause pulse and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R10: After `rstN` every output is 0. Status bit 6 always reads 0. `chipRstOut` and `coreRstOut` do not clear the status flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous power-domain reset |
| srcPor | input | 1 | Power-on reset pulse |
| srcPin | input | 1 | External pin reset pulse |
| srcWdt | input | 1 | Watchdog reset pulse |
| srcLvr | input | 1 | Low-voltage reset pulse |
| srcBod | input | 1 | Brown-out reset pulse |
| srcSysReq | input | 1 | Processor reset request pulse |
| srcLockup | input | 1 | Processor lockup pulse |
| dbgAttached | input | 1 | Debugger attached level |
| dbgRst | input | 1 | Debugger reset command pulse |
| unlocked | input | 1 | Write-protect released |
| wrEn | input | 1 | Write strobe |
| wrSel | input | 2 | Target: 0 status, 1 one-shot control, 2 power-on key, 3 none |
| wrData | input | 16 | Write data |
| statusOut | output | 9 | Sticky reset cause flags |
| chipRstOut | output | 1 | Chip reset pulse |
| coreRstOut | output | 1 | Processor core reset pulse |
| porOff | output | 1 | Power-on detector disabled |
| lockupRstOut | output | 1 | Lockup reset pulse |

## Verification
Every result passes through one register stage. A cause flag, a cleared flag, a key change and the lockup pulse all appear in the cycle after the input is sampled. A one-shot pulse appears in the cycle after its write and lasts exactly two cycles. The bench drives inputs on the falling edge and updates a reference model at the rising edge. It compares every output on the next falling edge, so each result is checked in the cycle it is due and in every cycle afterwards, across directed sequences and a long seeded random run.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;
  localparam int STAT_W = 9;
  localparam int KEY_W  = 16;
  localparam int SEL_W  = 2;

  // cause flag positions (software decodes these)
  localparam int POS_POR    = 0;
  localparam int POS_PIN    = 1;
  localparam int POS_WDT    = 2;
  localparam int POS_LVR    = 3;
  localparam int POS_BOD    = 4;
  localparam int POS_SYSREQ = 5;
  localparam int POS_CORE   = 7;
  localparam int POS_LOCKUP = 8;

  // one-shot control bits
  localparam int OS_CHIP = 0;
  localparam int OS_CORE = 1;

  localparam logic [SEL_W-1:0] SEL_STATUS  = 2'd0;
  localparam logic [SEL_W-1:0] SEL_ONESHOT = 2'd1;
  localparam logic [SEL_W-1:0] SEL_PORKEY  = 2'd2;

  typedef struct packed {
    logic [STAT_W-1:0] clrMask;
    logic              chipStart;
    logic              coreStart;
    logic              keyLoad;
    logic [KEY_W-1:0]  keyData;
  } ctrlStrobe_t;
endpackage

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
  import rst_cause_pkg::*;
#(
  parameter int PULSE_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [KEY_W-1:0]  wrData,
  input  logic              unlocked,
  output ctrlStrobe_t       strb,
  output logic              chipRstOut,
  output logic              coreRstOut
);
  localparam int CNT_W = $clog2(PULSE_CYCLES + 1);
  localparam int N_OS  = 2;

  logic protWr;
  logic [N_OS-1:0] startVec;
  logic [N_OS-1:0] activeVec;

  always_comb begin
    protWr         = wrEn && unlocked;
    strb.clrMask   = (wrEn && wrSel == SEL_STATUS) ? wrData[STAT_W-1:0] : '0;
    strb.chipStart = protWr && wrSel == SEL_ONESHOT && wrData[OS_CHIP];
    strb.coreStart = protWr && wrSel == SEL_ONESHOT && wrData[OS_CORE];
    strb.keyLoad   = protWr && wrSel == SEL_PORKEY;
    strb.keyData   = wrData;
  end

  assign startVec[OS_CHIP] = strb.chipStart;
  assign startVec[OS_CORE] = strb.coreStart;

  genvar g;
  generate
    for (g = 0; g < N_OS; g++) begin : g_oneshot
      logic [CNT_W-1:0] cnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)            cnt <= '0;
        else if (startVec[g]) cnt <= CNT_W'(PULSE_CYCLES);
        else if (cnt != '0)   cnt <= cnt - 1'b1;
      end
      assign activeVec[g] = (cnt != '0);
    end
  endgenerate

  assign chipRstOut = activeVec[OS_CHIP];
  assign coreRstOut = activeVec[OS_CORE];

  // R5
  locked_chip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == SEL_ONESHOT && !unlocked && !chipRstOut) |=> !chipRstOut);

  // R3
  chip_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(chipRstOut) |=> chipRstOut);

  // R4
  core_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(coreRstOut) |=> coreRstOut);
endmodule

// File: rtl/rst_cause_dp.sv
module rst_cause_dp
  import rst_cause_pkg::*;
#(
  parameter logic [KEY_W-1:0] KEY_VALUE = 16'h5AA5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              srcPor,
  input  logic              srcPin,
  input  logic              srcWdt,
  input  logic              srcLvr,
  input  logic              srcBod,
  input  logic              srcSysReq,
  input  logic              srcLockup,
  input  logic              dbgAttached,
  input  logic              dbgRst,
  input  ctrlStrobe_t       strb,
  output logic [STAT_W-1:0] statusOut,
  output logic              porOff,
  output logic              lockupRstOut
);
  logic [STAT_W-1:0] setVec;
  logic [KEY_W-1:0]  keyReg;
  logic              keyCancel;

  always_comb begin
    setVec             = '0;
    setVec[POS_POR]    = srcPor | strb.chipStart;
    setVec[POS_PIN]    = srcPin;
    setVec[POS_WDT]    = srcWdt;
    setVec[POS_LVR]    = srcLvr;
    setVec[POS_BOD]    = srcBod;
    setVec[POS_SYSREQ] = srcSysReq;
    setVec[POS_CORE]   = strb.coreStart;
    setVec[POS_LOCKUP] = srcLockup;
  end

  genvar b;
  generate
    for (b = 0; b < STAT_W; b++) begin : g_flag
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) statusOut[b] <= 1'b0;
        else       statusOut[b] <= setVec[b] | (statusOut[b] & ~strb.clrMask[b]);
      end
    end
  endgenerate

  assign keyCancel = srcPin | srcWdt | srcLvr | srcBod | dbgRst | strb.chipStart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyReg       <= '0;
      lockupRstOut <= 1'b0;
    end else begin
      if (keyCancel)         keyReg <= '0;
      else if (strb.keyLoad) keyReg <= strb.keyData;
      lockupRstOut <= srcLockup & ~dbgAttached;
    end
  end

  assign porOff = (keyReg == KEY_VALUE);

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (srcWdt && strb.clrMask[POS_WDT]) |=> statusOut[POS_WDT]);

  // R2
  clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrMask[POS_BOD] && !srcBod) |=> !statusOut[POS_BOD]);

  // R7
  rearm_chk: assert property (@(posedge clk) disable iff (!rstN)
    (srcPin || srcWdt || srcLvr || srcBod || dbgRst) |=> !porOff);

  // R8
  dbg_lockup_chk: assert property (@(posedge clk) disable iff (!rstN)
    (srcLockup && dbgAttached) |=> (!lockupRstOut && statusOut[POS_LOCKUP]));
endmodule

// File: rtl/rst_cause_unit.sv
module rst_cause_unit
  import rst_cause_pkg::*;
#(
  parameter int                PULSE_CYCLES = 2,
  parameter logic [KEY_W-1:0]  KEY_VALUE    = 16'h5AA5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              srcPor,
  input  logic              srcPin,
  input  logic              srcWdt,
  input  logic              srcLvr,
  input  logic              srcBod,
  input  logic              srcSysReq,
  input  logic              srcLockup,
  input  logic              dbgAttached,
  input  logic              dbgRst,
  input  logic              unlocked,
  input  logic              wrEn,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [KEY_W-1:0]  wrData,
  output logic [STAT_W-1:0] statusOut,
  output logic              chipRstOut,
  output logic              coreRstOut,
  output logic              porOff,
  output logic              lockupRstOut
);
  ctrlStrobe_t strb;

  rst_cause_ctrl #(.PULSE_CYCLES(PULSE_CYCLES)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .unlocked(unlocked), .strb(strb),
    .chipRstOut(chipRstOut), .coreRstOut(coreRstOut)
  );

  rst_cause_dp #(.KEY_VALUE(KEY_VALUE)) i_dp (
    .clk(clk), .rstN(rstN), .srcPor(srcPor), .srcPin(srcPin), .srcWdt(srcWdt),
    .srcLvr(srcLvr), .srcBod(srcBod), .srcSysReq(srcSysReq),
    .srcLockup(srcLockup), .dbgAttached(dbgAttached), .dbgRst(dbgRst),
    .strb(strb), .statusOut(statusOut), .porOff(porOff),
    .lockupRstOut(lockupRstOut)
  );

  // R10
  status_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chipRstOut && !wrEn && !srcPor && statusOut[POS_PIN]) |=> statusOut[POS_PIN]);

  // R10
  spare_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    !statusOut[6]);
endmodule

// File: tb/test_rst_cause_unit.sv
module test_rst_cause_unit;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN;
  logic srcPor, srcPin, srcWdt, srcLvr, srcBod, srcSysReq, srcLockup;
  logic dbgAttached, dbgRst, unlocked, wrEn;
  logic [1:0]  wrSel;
  logic [15:0] wrData;
  logic [8:0]  statusOut;
  logic chipRstOut, coreRstOut, porOff, lockupRstOut;

  rst_cause_unit i_rst_cause_unit (
    .clk(clk), .rstN(rstN), .srcPor(srcPor), .srcPin(srcPin), .srcWdt(srcWdt),
    .srcLvr(srcLvr), .srcBod(srcBod), .srcSysReq(srcSysReq),
    .srcLockup(srcLockup), .dbgAttached(dbgAttached), .dbgRst(dbgRst),
    .unlocked(unlocked), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .statusOut(statusOut), .chipRstOut(chipRstOut), .coreRstOut(coreRstOut),
    .porOff(porOff), .lockupRstOut(lockupRstOut)
  );

  int nChecks = 0;
  int nFail   = 0;

  logic [8:0]  mSt;
  logic [15:0] mKey;
  int          mChip, mCore;
  logic        mLock;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [8:0] nextStatus(input logic [8:0] cur, input logic chipReq,
                                            input logic coreReq);
    logic [8:0] setV;
    logic [8:0] clrV;
    setV = {srcLockup, coreReq, 1'b0, srcSysReq, srcBod, srcLvr, srcWdt, srcPin,
            srcPor | chipReq};
    clrV = (wrEn && wrSel == 2'd0) ? wrData[8:0] : 9'h0;
    return ((cur & ~clrV) | setV) & 9'h1BF;
  endfunction

  task automatic idleIns();
    {srcPor, srcPin, srcWdt, srcLvr, srcBod, srcSysReq, srcLockup} = '0;
    {dbgAttached, dbgRst, unlocked, wrEn} = '0;
    wrSel = 2'd3;
    wrData = '0;
  endtask

  task automatic stepCycle();
    logic chipReq, coreReq;
    chipReq = wrEn && unlocked && wrSel == 2'd1 && wrData[0];
    coreReq = wrEn && unlocked && wrSel == 2'd1 && wrData[1];
    @(posedge clk);
    mSt   = nextStatus(mSt, chipReq, coreReq);
    mChip = chipReq ? 2 : (mChip > 0 ? mChip - 1 : 0);
    mCore = coreReq ? 2 : (mCore > 0 ? mCore - 1 : 0);
    if (srcPin | srcWdt | srcLvr | srcBod | dbgRst | chipReq) mKey = '0;
    else if (wrEn && unlocked && wrSel == 2'd2)               mKey = wrData;
    mLock = srcLockup && !dbgAttached;
    @(negedge clk);
    check("R1 R2 R9 R10 statusOut", 32'(statusOut), 32'(mSt));
    check("R3 R5 chipRstOut", 32'(chipRstOut), 32'(mChip != 0));
    check("R4 R5 coreRstOut", 32'(coreRstOut), 32'(mCore != 0));
    check("R6 R7 porOff", 32'(porOff), 32'(mKey == 16'h5AA5));
    check("R8 lockupRstOut", 32'(lockupRstOut), 32'(mLock));
    idleIns();
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d, input logic unl);
    wrEn = 1'b1; wrSel = sel; wrData = d; unlocked = unl;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    idleIns();
    rstN = 1'b0;
    mSt = '0; mKey = '0; mChip = 0; mCore = 0; mLock = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R10 reset state
    check("R10 reset statusOut", 32'(statusOut), 32'h0);
    check("R10 reset pulses", 32'({chipRstOut, coreRstOut, lockupRstOut}), 32'h0);
    check("R10 reset porOff", 32'(porOff), 32'h0);

    // R5 locked key write ignored
    wr(2'd2, 16'h5AA5, 1'b0); stepCycle();
    // R6 unlocked key write
    wr(2'd2, 16'h5AA5, 1'b1); stepCycle();
    // R6 other value turns detector back on
    wr(2'd2, 16'h1234, 1'b1); stepCycle();
    wr(2'd2, 16'h5AA5, 1'b1); stepCycle();
    // R7 pin reset beats a key write in the same cycle
    wr(2'd2, 16'h5AA5, 1'b1); srcPin = 1'b1; stepCycle();
    wr(2'd2, 16'h5AA5, 1'b1); stepCycle();
    // R3 chip one-shot, width and re-arm of the key
    wr(2'd1, 16'h0001, 1'b1); stepCycle();
    repeat (3) stepCycle();
    // R5 locked core write ignored, R4 unlocked core write
    wr(2'd1, 16'h0002, 1'b0); stepCycle();
    wr(2'd1, 16'h0002, 1'b1); stepCycle();
    repeat (3) stepCycle();
    // R9 set and clear on the same flag
    srcWdt = 1'b1; wr(2'd0, 16'h0004, 1'b0); stepCycle();
    // R2 clear alone, other flags kept
    wr(2'd0, 16'h0004, 1'b0); stepCycle();
    // R8 lockup with and without debugger
    srcLockup = 1'b1; dbgAttached = 1'b1; stepCycle();
    srcLockup = 1'b1; stepCycle();
    stepCycle();
    // R2 clear every flag
    wr(2'd0, 16'h01FF, 1'b0); stepCycle();

    void'($urandom(32'hC0FFEE));
    for (int i = 0; i < 4000; i++) begin
      srcPor      = ($urandom % 16) == 0;
      srcPin      = ($urandom % 12) == 0;
      srcWdt      = ($urandom % 12) == 0;
      srcLvr      = ($urandom % 12) == 0;
      srcBod      = ($urandom % 12) == 0;
      srcSysReq   = ($urandom % 12) == 0;
      srcLockup   = ($urandom % 12) == 0;
      dbgAttached = $urandom % 2;
      dbgRst      = ($urandom % 16) == 0;
      unlocked    = $urandom % 2;
      wrEn        = $urandom % 2;
      wrSel       = 2'($urandom % 4);
      wrData      = 16'($urandom);
      if (wrSel == 2'd2 && ($urandom % 2) == 1) wrData = 16'h5AA5;
      stepCycle();
    end

    summary();
    $finish;
  end
endmodule